// File: doc/BRIEF.md
# Two-Pattern Nibble Sequence Detector

This block watches a serial bit stream, one bit per clock when its valid qualifier is high, and cuts the stream into consecutive groups of four bits that never overlap. On the cycle that carries the fourth bit of a group, a combinational Mealy output goes high for that cycle only if the group, read in arrival order, is `0110` or `1010`. On every other cycle the output stays low. After the fourth bit the machine starts a fresh group.

The detector is a minimised seven-state machine. States that share a future are merged. After two bits, the two prefixes whose remaining suffix can still complete a pattern are kept apart from the two that cannot. After three bits, one state can still produce a hit and one cannot. A parameter picks the binary code stored in the three state flops. The default is an adjacency-driven code that gives sibling states codes one bit apart. The alternative is a plain sequential numbering. Both choices show the same behaviour at the ports.

A synchronous reset puts the machine back at the start of a group, so the next valid bit becomes bit one. When the qualifier is low, the state holds and the output is low.

Top module: `nibdet_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to its group-start state. The first valid bit after reset is bit one of a group.
- R2: Groups are back to back and never overlap. A matching 4-bit pattern that straddles a group boundary produces no hit. After the fourth valid bit, the next valid bit starts a new group.
- R3: `hit` is 1 during the cycle in which the fourth valid bit of a group is presented, when the group's bits in arrival order are 0,1,1,0.
- R4: `hit` is 1 during the cycle in which the fourth valid bit of a group is presented, when the group's bits in arrival order are 1,0,1,0.
- R5: For the other fourteen 4-bit groups, and on the first three bits of every group, `hit` is 0.
- R6: While `bit_vld` is 0, `hit` is 0 and the group position and the stored bits do not change, whatever `bit_in` does. A group interrupted by invalid cycles completes normally afterwards.
- R7: A reset applied in the middle of a group discards the partial group.
- R8: The stream 0010 0110 1100 1010 0011, presented on consecutive valid cycles, produces the `hit` sequence 0000 0001 0000 0001 0000.
- R9: Parameter `ENC` = 0 selects the adjacency state code (start 000, then 001/101 after one bit, 011/111 after two bits, 010/110 after three bits). `ENC` = 1 selects sequential codes 000 to 110. Both give identical port behaviour, and the unused code never appears after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to group start |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifier: `bit_in` is consumed only when high |
| hit | output | 1 | Combinational Mealy detect, high on the fourth bit of a matching group |

## Verification
A corrupted state register shows at the ports mainly as a misplaced group boundary. Hits then appear one or more groups late, on the wrong bit, or not at all. A wrong branch among the sibling states shows as a missed or spurious hit within the same group. Every such fault becomes visible within at most two groups of valid bits. Because of this, the bench drives every 4-bit pattern through two instances, one per state code. It also repeats each pattern with idle gaps and resets placed at each position, and checks `hit` on every presented bit.

// File: rtl/nibdet_pkg.sv
package nibdet_pkg;

    // Symbolic states: position in group plus what is still reachable
    typedef enum logic [2:0] {
        SY_START = 3'd0,   // no bits of current group yet
        SY_ONE0  = 3'd1,   // first bit was 0
        SY_ONE1  = 3'd2,   // first bit was 1
        SY_DEAD2 = 3'd3,   // two bits, no pattern reachable
        SY_LIVE2 = 3'd4,   // two bits, "01" or "10"
        SY_DEAD3 = 3'd5,   // three bits, no pattern reachable
        SY_LIVE3 = 3'd6,   // three bits, "011" or "101"
        SY_BAD   = 3'd7    // illegal stored code
    } sym_t;

    localparam int CODE_W = 3;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } nib_regs_t;

endpackage

// File: rtl/nibdet_step.sv
module nibdet_step
    import nibdet_pkg::*;
(
    input  sym_t cur,
    input  logic din,
    output sym_t nxt,
    output logic mealy
);

    always_comb begin
        nxt   = SY_START;
        mealy = 1'b0;
        unique case (cur)
            SY_START: nxt = din ? SY_ONE1 : SY_ONE0;
            SY_ONE0:  nxt = din ? SY_LIVE2 : SY_DEAD2;
            SY_ONE1:  nxt = din ? SY_DEAD2 : SY_LIVE2;
            SY_DEAD2: nxt = SY_DEAD3;
            SY_LIVE2: nxt = din ? SY_LIVE3 : SY_DEAD3;
            SY_DEAD3: nxt = SY_START;
            SY_LIVE3: begin
                nxt   = SY_START;
                mealy = ~din;
            end
            default:  nxt = SY_START;   // recovery from an illegal code
        endcase
    end

endmodule

// File: rtl/nibdet_codec.sv
module nibdet_codec
    import nibdet_pkg::*;
#(
    parameter int ENC = 0
) (
    input  sym_t              sym_in,
    output logic [CODE_W-1:0] code_out,
    input  logic [CODE_W-1:0] code_in,
    output sym_t              sym_out
);

    generate
        if (ENC == 0) begin : g_adjacent
            always_comb begin
                unique case (sym_in)
                    SY_ONE0:  code_out = 3'b001;
                    SY_ONE1:  code_out = 3'b101;
                    SY_DEAD2: code_out = 3'b011;
                    SY_LIVE2: code_out = 3'b111;
                    SY_DEAD3: code_out = 3'b010;
                    SY_LIVE3: code_out = 3'b110;
                    default:  code_out = 3'b000;
                endcase
            end
            always_comb begin
                unique case (code_in)
                    3'b000:  sym_out = SY_START;
                    3'b001:  sym_out = SY_ONE0;
                    3'b101:  sym_out = SY_ONE1;
                    3'b011:  sym_out = SY_DEAD2;
                    3'b111:  sym_out = SY_LIVE2;
                    3'b010:  sym_out = SY_DEAD3;
                    3'b110:  sym_out = SY_LIVE3;
                    default: sym_out = SY_BAD;
                endcase
            end
        end else begin : g_sequential
            always_comb begin
                if (sym_in == SY_BAD) code_out = 3'b000;
                else                  code_out = 3'(sym_in);
            end
            always_comb begin
                if (code_in == 3'b111) sym_out = SY_BAD;
                else                   sym_out = sym_t'(code_in);
            end
        end
    endgenerate

endmodule

// File: rtl/nibdet_top.sv
module nibdet_top
    import nibdet_pkg::*;
#(
    parameter int ENC = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic hit
);

    localparam logic [CODE_W-1:0] CODE_START  = '0;
    localparam logic [CODE_W-1:0] CODE_UNUSED = (ENC == 0) ? 3'b100 : 3'b111;

    nib_regs_t         regs_q, regs_d;
    sym_t              cur_sym, nxt_sym;
    logic [CODE_W-1:0] nxt_code;
    logic              mealy;

    nibdet_codec #(.ENC(ENC)) codec_i (
        .sym_in   (nxt_sym),
        .code_out (nxt_code),
        .code_in  (regs_q.code),
        .sym_out  (cur_sym)
    );

    nibdet_step step_i (
        .cur   (cur_sym),
        .din   (bit_in),
        .nxt   (nxt_sym),
        .mealy (mealy)
    );

    always_comb begin
        regs_d = regs_q;
        if (bit_vld) regs_d.code = nxt_code;
        hit = bit_vld & mealy;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q.code <= CODE_START;
        else     regs_q      <= regs_d;
    end

    assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> regs_q.code == CODE_START);

    assert_hit_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        hit |=> regs_q.code == CODE_START);

    assert_hit_last_zero_R3: assert property (@(posedge clk) disable iff (rst)
        hit |-> !bit_in);

    assert_idle_no_hit_R6: assert property (@(posedge clk) disable iff (rst)
        hit |-> bit_vld);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(regs_q.code));

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        regs_q.code != CODE_UNUSED);

endmodule

// File: tb/nibdet_top_tb_top.sv
`timescale 1ns/1ps
module nibdet_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic hit_adj, hit_seq;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    logic [2:0] hist = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nibdet_top #(.ENC(0)) dut_i (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .hit(hit_adj)
    );

    nibdet_top #(.ENC(1)) dut_seq_i (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .hit(hit_seq)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string who);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: hit=%b expected %b (t=%0t)", tag, who, act, exp, $time);
        end
    endtask

    // Present one bit, check both instances, then model the clock edge.
    task automatic drive(input logic b, input logic v, input string tag);
        logic exp;
        @(negedge clk);
        bit_in  = b;
        bit_vld = v;
        #2;
        exp = v && (pos == 3) && ({hist, b} == 4'b0110 || {hist, b} == 4'b1010);
        check(hit_adj, exp, tag, "ENC0");
        check(hit_seq, exp, tag, "ENC1");
        check(hit_seq, hit_adj, "R9", "ENC1 vs ENC0");
        if (v) begin
            hist = {hist[1:0], b};
            pos  = (pos == 3) ? 0 : pos + 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        pos = 0;
    endtask

    function automatic string pat_tag(input logic [3:0] p);
        if (p == 4'b0110) return "R3";
        if (p == 4'b1010) return "R4";
        return "R5";
    endfunction

    initial begin
        logic [19:0] stream;
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] stream;
        repeat (3) @(posedge clk);
        do_reset();
        // R1: first valid bits after reset form a group
        drive(1'b0, 1'b1, "R1");
        drive(1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, "R1");
        drive(1'b0, 1'b1, "R1");

        // R3 R4 R5: every 4-bit group, MSB first
        for (int p = 0; p < 16; p++) begin
            for (int k = 3; k >= 0; k--) drive(p[k], 1'b1, pat_tag(4'(p)));
        end

        // R6: idle gap before each position, with toggling bit_in
        for (int p = 0; p < 16; p++) begin
            for (int gap = 0; gap < 4; gap++) begin
                for (int k = 3; k >= 0; k--) begin
                    if (3 - k == gap) begin
                        drive(~p[k], 1'b0, "R6");
                        drive(p[k], 1'b0, "R6");
                    end
                    drive(p[k], 1'b1, pat_tag(4'(p)));
                end
            end
        end

        // R2: 0110 straddling a boundary must not hit
        drive(1'b1, 1'b1, "R2");
        drive(1'b0, 1'b1, "R2");
        drive(1'b1, 1'b1, "R2");
        drive(1'b0, 1'b1, "R2");
        drive(1'b1, 1'b1, "R2");
        drive(1'b1, 1'b1, "R2");
        drive(1'b0, 1'b1, "R2");
        drive(1'b0, 1'b1, "R2");

        // R7: reset after 1..3 bits, then a matching group
        for (int n = 1; n < 4; n++) begin
            for (int k = 0; k < n; k++) drive(1'b1, 1'b1, "R7");
            do_reset();
            drive(1'b1, 1'b1, "R7");
            drive(1'b0, 1'b1, "R7");
            drive(1'b1, 1'b1, "R7");
            drive(1'b0, 1'b1, "R7");
        end

        // R8: example stream
        do_reset();
        stream = 20'b0010_0110_1100_1010_0011;
        for (int k = 19; k >= 0; k--) drive(stream[k], 1'b1, "R8");

        // R9: long mixed run comparing both codes
        for (int i = 0; i < 200; i++) drive(1'((i * 7 + i / 3) % 2), 1'(i % 5 != 2), "R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule